// File: doc/BRIEF.md
# Pipelined SAD Readout Network

This block gathers the accumulated error words from a row-organised array of block-matching processing elements and hands one sum of absolute differences per cycle to a downstream minimum-search comparator. Rather than a single wide multiplexer over every element, the selection is staged. Each error word is split into two parts. The upper part passes through short cascaded multiplexer chains over halves of a group, is registered, and then goes through a 2:1 choice between the two halves. The lower part travels on a shared one-hot bus for each row. Delay registers bring the two parts back into line before a per-row 2:1 stage. That stage either takes its own row's word or passes on the word from the row before it.

Each cycle a controller presents a one-hot element (column) select that applies to every row, a row select vector, and a valid flag. A fixed number of cycles later the network returns the chosen element's error word exactly as it was presented in the select cycle, together with a matching valid flag. When several rows are selected, the highest-numbered one wins. Group size, group count, row count, word widths and whether a final output register is present are all parameters.

Top module: `sad_readout_net`

## Requirements
- R1: When `in_valid` is high in cycle t, `out_sad` in cycle t+LAT equals the error word of the selected element as presented in cycle t. LAT is 3 with the output register enabled (the default) and 2 without it. Element e of row r occupies bits [(r*ROW_ELEMS+e)*ERR_W +: ERR_W] of `err_flat`.
- R2: `out_valid` in cycle t+LAT equals `in_valid` in cycle t, for every cycle pattern including gaps.
- R3: Selections in consecutive cycles produce independent results on consecutive cycles, with no stall and no mixing between cycles.
- R4: Bit e of `col_sel` picks element e inside every row. Every element position of a row is reachable. `col_sel` is one-hot or zero whenever `in_valid` is high.
- R5: Bit r of `row_sel` picks row r. When several bits are set, the row with the highest index wins.
- R6: With `row_sel` all zero, the result is zero.
- R7: With `col_sel` all zero, the result is zero for any `row_sel`.
- R8: The low LO_W bits and the high ERR_W-LO_W bits of a result both come from the same element and the same input cycle, including at all-ones and half-ones extreme values, while the inputs change every cycle.
- R9: While reset is held, and in the first cycle after release, `out_valid` and `out_sad` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks a readout request this cycle |
| col_sel | input | ROW_ELEMS | One-hot element select, shared by all rows |
| row_sel | input | ROWS | Row select, highest set index has priority |
| err_flat | input | ROWS*ROW_ELEMS*ERR_W | Accumulated errors of all elements |
| out_valid | output | 1 | Valid flag aligned with `out_sad` |
| out_sad | output | ERR_W | Selected error word |

## Verification
The bench builds the network with half-groups of 2, 2 groups per row and 2 rows, so 16 elements with the default 19/10-bit split and the output register on. At this size every element position in both rows can be selected many times over with fresh error values each cycle. All four row-select codes can be paired with every column, so the priority chain, the zero cases and the realignment of the two paths are each covered at every position rather than sampled.

// File: rtl/sad_rd_pkg.sv
package sad_rd_pkg;

   localparam int unsigned DEF_ERR_W = 19;
   localparam int unsigned DEF_LO_W  = 10;

   // Two register stages ahead of the row chain, plus the optional output register.
   function automatic int unsigned rd_latency(input bit out_reg);
      return out_reg ? 3 : 2;
   endfunction

endpackage

// File: rtl/sad_half_cascade.sv
// Cascaded 2:1 chain over one half-group for the upper bits (combinational).
module sad_half_cascade #(
   parameter int unsigned HI_W    = 9,
   parameter int unsigned HALF_SZ = 8
) (
   input  logic [HALF_SZ*HI_W-1:0] hi_i,
   input  logic [HALF_SZ-1:0]      sel_i,
   output logic [HI_W-1:0]         hi_o,
   output logic                    hit_o
);

   logic [HI_W-1:0] link [HALF_SZ+1];

   assign link[0] = '0;

   for (genvar k = 0; k < HALF_SZ; k++) begin : g_link
      assign link[k+1] = sel_i[k] ? hi_i[k*HI_W +: HI_W] : link[k];
   end

   assign hi_o  = link[HALF_SZ];
   assign hit_o = |sel_i;

endmodule

// File: rtl/sad_group.sv
// Two half-groups, each registered, then a 2:1 choice between them.
module sad_group #(
   parameter int unsigned HI_W    = 9,
   parameter int unsigned HALF_SZ = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [2*HALF_SZ*HI_W-1:0] hi_i,
   input  logic [2*HALF_SZ-1:0]      sel_i,
   output logic [HI_W-1:0]           hi_o,
   output logic                      hit_o
);

   localparam int unsigned HALF_BITS = HALF_SZ*HI_W;

   logic [1:0][HI_W-1:0] half_hi;
   logic [1:0]           half_hit;
   logic [1:0][HI_W-1:0] half_hi_q;
   logic [1:0]           half_hit_q;

   for (genvar h = 0; h < 2; h++) begin : g_half
      sad_half_cascade #(
         .HI_W    (HI_W),
         .HALF_SZ (HALF_SZ)
      ) half_i (
         .hi_i  (hi_i[h*HALF_BITS +: HALF_BITS]),
         .sel_i (sel_i[h*HALF_SZ +: HALF_SZ]),
         .hi_o  (half_hi[h]),
         .hit_o (half_hit[h])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_hi_q  <= '0;
         half_hit_q <= '0;
      end else begin
         half_hi_q  <= half_hi;
         half_hit_q <= half_hit;
      end
   end

   assign hi_o  = half_hit_q[1] ? half_hi_q[1] : half_hi_q[0];
   assign hit_o = |half_hit_q;

endmodule

// File: rtl/sad_row.sv
// One row: upper bits through groups plus one register, lower bits on a
// shared one-hot bus plus two registers, both landing aligned.
module sad_row #(
   parameter int unsigned ERR_W   = 19,
   parameter int unsigned LO_W    = 10,
   parameter int unsigned HALF_SZ = 8,
   parameter int unsigned GRPS    = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [2*HALF_SZ*GRPS*ERR_W-1:0] err_i,
   input  logic [2*HALF_SZ*GRPS-1:0]     sel_i,
   output logic [ERR_W-1:0]              err_o
);

   localparam int unsigned HI_W      = ERR_W - LO_W;
   localparam int unsigned GRP_ELEMS = 2*HALF_SZ;
   localparam int unsigned ROW_ELEMS = GRP_ELEMS*GRPS;

   logic [ROW_ELEMS*HI_W-1:0] hi_all;
   logic [ROW_ELEMS*LO_W-1:0] lo_all;

   for (genvar e = 0; e < ROW_ELEMS; e++) begin : g_split
      assign lo_all[e*LO_W +: LO_W] = err_i[e*ERR_W +: LO_W];
      assign hi_all[e*HI_W +: HI_W] = err_i[e*ERR_W+LO_W +: HI_W];
   end

   // Upper path
   logic [HI_W-1:0] grp_hi   [GRPS];
   logic [GRPS-1:0] grp_hit;
   logic [HI_W-1:0] grp_link [GRPS+1];

   assign grp_link[0] = '0;

   for (genvar g = 0; g < GRPS; g++) begin : g_grp
      sad_group #(
         .HI_W    (HI_W),
         .HALF_SZ (HALF_SZ)
      ) grp_i (
         .clk   (clk),
         .rst_n (rst_n),
         .hi_i  (hi_all[g*GRP_ELEMS*HI_W +: GRP_ELEMS*HI_W]),
         .sel_i (sel_i[g*GRP_ELEMS +: GRP_ELEMS]),
         .hi_o  (grp_hi[g]),
         .hit_o (grp_hit[g])
      );
      assign grp_link[g+1] = grp_hit[g] ? grp_hi[g] : grp_link[g];
   end

   // Lower path: shared bus modelled as one-hot AND-OR
   logic [LO_W-1:0] lo_bus;

   always_comb begin
      lo_bus = '0;
      for (int e = 0; e < ROW_ELEMS; e++) begin
         if (sel_i[e]) lo_bus |= lo_all[e*LO_W +: LO_W];
      end
   end

   logic [HI_W-1:0] hi_q;
   logic [LO_W-1:0] lo_d1;
   logic [LO_W-1:0] lo_d2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q  <= '0;
         lo_d1 <= '0;
         lo_d2 <= '0;
      end else begin
         hi_q  <= grp_link[GRPS];
         lo_d1 <= lo_bus;
         lo_d2 <= lo_d1;
      end
   end

   assign err_o = {hi_q, lo_d2};

endmodule

// File: rtl/sad_readout_net.sv
module sad_readout_net #(
   parameter int unsigned ERR_W   = sad_rd_pkg::DEF_ERR_W,
   parameter int unsigned LO_W    = sad_rd_pkg::DEF_LO_W,
   parameter int unsigned HALF_SZ = 8,
   parameter int unsigned GRPS    = 4,
   parameter int unsigned ROWS    = 4,
   parameter bit          OUT_REG = 1'b1,
   localparam int unsigned ROW_ELEMS = 2*HALF_SZ*GRPS,
   localparam int unsigned N_ELEMS   = ROWS*ROW_ELEMS
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [ROW_ELEMS-1:0]     col_sel,
   input  logic [ROWS-1:0]          row_sel,
   input  logic [N_ELEMS*ERR_W-1:0] err_flat,
   output logic                     out_valid,
   output logic [ERR_W-1:0]         out_sad
);

   localparam int unsigned LAT      = sad_rd_pkg::rd_latency(OUT_REG);
   localparam int unsigned ROW_BITS = ROW_ELEMS*ERR_W;

   if (LO_W < 1 || LO_W >= ERR_W) begin : g_bad_split
      $error("LO_W must lie between 1 and ERR_W-1");
   end
   if (HALF_SZ < 1 || GRPS < 1 || ROWS < 1) begin : g_bad_shape
      $error("HALF_SZ, GRPS and ROWS must be at least 1");
   end

   logic [ERR_W-1:0] row_err [ROWS];

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      sad_row #(
         .ERR_W   (ERR_W),
         .LO_W    (LO_W),
         .HALF_SZ (HALF_SZ),
         .GRPS    (GRPS)
      ) row_i (
         .clk   (clk),
         .rst_n (rst_n),
         .err_i (err_flat[r*ROW_BITS +: ROW_BITS]),
         .sel_i (col_sel),
         .err_o (row_err[r])
      );
   end

   // Row select follows the two stages ahead of the row chain.
   logic [ROWS-1:0] rsel_d1;
   logic [ROWS-1:0] rsel_d2;
   logic [LAT-1:0]  vld_pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsel_d1  <= '0;
         rsel_d2  <= '0;
         vld_pipe <= '0;
      end else begin
         rsel_d1  <= row_sel;
         rsel_d2  <= rsel_d1;
         vld_pipe <= {vld_pipe[LAT-2:0], in_valid};
      end
   end

   // Priority chain: a later row overrides anything passed from before it.
   logic [ERR_W-1:0] chain [ROWS+1];

   assign chain[0] = '0;

   for (genvar r = 0; r < ROWS; r++) begin : g_chain
      assign chain[r+1] = rsel_d2[r] ? row_err[r] : chain[r];
   end

   if (OUT_REG) begin : g_oreg
      logic [ERR_W-1:0] sad_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sad_q <= '0;
         else        sad_q <= chain[ROWS];
      end
      assign out_sad = sad_q;
   end else begin : g_ocomb
      assign out_sad = chain[ROWS];
   end

   assign out_valid = vld_pipe[LAT-1];

endmodule

// File: rtl/sad_readout_net_chk.sv
module sad_readout_net_chk #(
   parameter int unsigned ERR_W     = 19,
   parameter int unsigned ROW_ELEMS = 64,
   parameter int unsigned ROWS      = 4,
   parameter bit          OUT_REG   = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic [ROW_ELEMS-1:0] col_sel,
   input logic [ROWS-1:0]      row_sel,
   input logic                 out_valid,
   input logic [ERR_W-1:0]     out_sad
);

   localparam int unsigned LAT = sad_rd_pkg::rd_latency(OUT_REG);

   logic [LAT-1:0] v_sh;
   logic [LAT-1:0] norow_sh;
   logic [LAT-1:0] nocol_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_sh     <= '0;
         norow_sh <= '0;
         nocol_sh <= '0;
      end else begin
         v_sh     <= {v_sh[LAT-2:0], in_valid};
         norow_sh <= {norow_sh[LAT-2:0], (row_sel == '0)};
         nocol_sh <= {nocol_sh[LAT-2:0], (col_sel == '0)};
      end
   end

   p_valid_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == v_sh[LAT-1]);

   p_colsel_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> $onehot0(col_sel));

   p_norow_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (v_sh[LAT-1] && norow_sh[LAT-1]) |-> (out_sad == '0));

   p_nocol_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (v_sh[LAT-1] && nocol_sh[LAT-1]) |-> (out_sad == '0));

   p_reset_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && out_sad == '0));

endmodule

bind sad_readout_net sad_readout_net_chk #(
   .ERR_W     (ERR_W),
   .ROW_ELEMS (ROW_ELEMS),
   .ROWS      (ROWS),
   .OUT_REG   (OUT_REG)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .col_sel   (col_sel),
   .row_sel   (row_sel),
   .out_valid (out_valid),
   .out_sad   (out_sad)
);

// File: tb/sad_readout_net_tb_top.sv
module sad_readout_net_tb_top;

   localparam int ERR_W = 19;
   localparam int LO_W  = 10;
   localparam int HALF  = 2;
   localparam int GRPS  = 2;
   localparam int ROWS  = 2;
   localparam int ROW_E = 2*HALF*GRPS;
   localparam int N     = ROWS*ROW_E;
   localparam int LAT   = 3;
   localparam int DEPTH = 4096;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic                 rst_n;
   logic                 in_valid;
   logic [ROW_E-1:0]     col_sel;
   logic [ROWS-1:0]      row_sel;
   logic [N*ERR_W-1:0]   err_flat;
   logic                 out_valid;
   logic [ERR_W-1:0]     out_sad;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   bit done    = 1'b0;

   logic [ERR_W-1:0] exp_sad [DEPTH];
   bit               exp_v   [DEPTH];
   string            exp_tag [DEPTH];

   sad_readout_net #(
      .ERR_W   (ERR_W),
      .LO_W    (LO_W),
      .HALF_SZ (HALF),
      .GRPS    (GRPS),
      .ROWS    (ROWS),
      .OUT_REG (1'b1)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .col_sel   (col_sel),
      .row_sel   (row_sel),
      .err_flat  (err_flat),
      .out_valid (out_valid),
      .out_sad   (out_sad)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, expv);
      end
   endtask

   function automatic logic [ERR_W-1:0] mix(input int seed, input int idx);
      logic [31:0] h;
      h = (seed * 32'h9E3779B1) ^ ((idx + 1) * 32'h85EBCA6B);
      h = h ^ (h >> 13);
      h = h * 32'hC2B2AE35;
      h = h ^ (h >> 16);
      return h[ERR_W-1:0];
   endfunction

   // mode 0: hashed, 1: all ones, 2: low part ones, 3: high part ones
   task automatic fill(input int seed, input int mode);
      for (int e = 0; e < N; e++) begin
         case (mode)
            1:       err_flat[e*ERR_W +: ERR_W] = '1;
            2:       err_flat[e*ERR_W +: ERR_W] = 19'h003FF ^ (19'(e) << LO_W);
            3:       err_flat[e*ERR_W +: ERR_W] = 19'h7FC00 ^ 19'(e);
            default: err_flat[e*ERR_W +: ERR_W] = mix(seed, e);
         endcase
      end
   endtask

   function automatic logic [ERR_W-1:0] model();
      int r;
      int c;
      r = -1;
      c = -1;
      for (int k = 0; k < ROWS; k++) if (row_sel[k]) r = k;
      for (int k = 0; k < ROW_E; k++) if (col_sel[k]) c = k;
      if (r < 0 || c < 0) return '0;
      return err_flat[(r*ROW_E + c)*ERR_W +: ERR_W];
   endfunction

   // One clock: check what the stimulus LAT cycles back produced, then drive.
   task automatic step(input bit v, input logic [ROWS-1:0] rs, input logic [ROW_E-1:0] cs,
                       input int seed, input int mode, input string tag);
      @(posedge clk);
      #1;
      if (cyc >= LAT) begin
         check(out_valid == exp_v[cyc-LAT], "R2", out_valid, exp_v[cyc-LAT]);
         if (exp_v[cyc-LAT])
            check(out_sad == exp_sad[cyc-LAT], exp_tag[cyc-LAT], out_sad, exp_sad[cyc-LAT]);
      end else begin
         check(out_valid == 1'b0, "R9", out_valid, 0);
         check(out_sad == '0, "R9", out_sad, 0);
      end
      in_valid = v;
      row_sel  = rs;
      col_sel  = cs;
      fill(seed, mode);
      exp_v[cyc]   = v;
      exp_sad[cyc] = model();
      exp_tag[cyc] = tag;
      cyc++;
   endtask

   initial begin
      rst_n    = 1'b0;
      in_valid = 1'b0;
      row_sel  = '0;
      col_sel  = '0;
      err_flat = '0;
      repeat (3) @(posedge clk);
      #1;
      check(out_valid == 1'b0, "R9", out_valid, 0);
      check(out_sad == '0, "R9", out_sad, 0);
      rst_n = 1'b1;

      // R1 / R4 / R3: every element of every row, back to back, fresh data each cycle
      for (int s = 0; s < 4; s++)
         for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < ROW_E; c++)
               step(1'b1, ROWS'(1) << r, ROW_E'(1) << c, s*100 + r*ROW_E + c, 0,
                    (s == 0) ? "R1" : ((s == 1) ? "R4" : "R3"));

      // R5: all row codes against every column (code 0 covers R6)
      for (int rs = 0; rs < (1 << ROWS); rs++)
         for (int c = 0; c < ROW_E; c++)
            step(1'b1, ROWS'(rs), ROW_E'(1) << c, 500 + rs*ROW_E + c, 0,
                 (rs == 0) ? "R6" : "R5");

      // R7: no column selected
      for (int rs = 0; rs < (1 << ROWS); rs++)
         step(1'b1, ROWS'(rs), '0, 700 + rs, 0, "R7");

      // R8: extreme split values alternated with hashed data
      for (int m = 1; m <= 3; m++)
         for (int c = 0; c < ROW_E; c++) begin
            step(1'b1, ROWS'(1) << (c % ROWS), ROW_E'(1) << c, 0, m, "R8");
            step(1'b1, ROWS'(1) << ((c + 1) % ROWS), ROW_E'(1) << (ROW_E-1-c), 800 + c, 0, "R8");
         end

      // R2: gaps in the valid stream
      for (int k = 0; k < 24; k++)
         step((k % 3) != 1, ROWS'(1) << (k % ROWS), ROW_E'(1) << (k % ROW_E), 900 + k, 0, "R2");

      // flush
      for (int k = 0; k < LAT + 1; k++)
         step(1'b0, '0, '0, 0, 0, "R2");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule